// File: doc/BRIEF.md
# DS3 Far-End Receive Failure Alarm Interrupt

This block follows the pair of X bits carried by every received DS3 frame and keeps a far-end receive failure alarm state. A frame whose two X bits are both 0 argues for the alarm. Any other combination argues against it. The state changes only after a run of consecutive frames that all argue against the current state. The run length is a parameter with a default of 3. Each change of state, whether the alarm is declared or cleared, is a change-of-state event.

An upstream framer presents one strobe per frame, together with the two X-bit values. Software reaches the block over a byte-wide register bus. The enable register sits at 0x12 and the status register at 0x13. Bit 3 of each belongs to this alarm. The other bits of both registers belong to alarm sources handled elsewhere, so they read 0 here. The status register clears itself when it is read. A spare address, 0x14, shows the live alarm state, so software can tell whether the last event was a declaration or a clear. An active-high interrupt line reports any pending enabled event.

Top module: `fe_alarm_irq`

## Requirements
- R1: After `PERSIST` consecutive frame strobes with both X bits 0, the alarm is declared. Bit 0 of address 0x14 reads 1 from the cycle after the last such strobe.
- R2: While the alarm is declared, `PERSIST` consecutive frame strobes whose X bits are not both 0 clear it, and bit 0 of 0x14 then reads 0.
- R3: A frame strobe that agrees with the current state restarts the consecutive count, so fewer than `PERSIST` matching frames after it leave the state unchanged. Cycles without a strobe do not affect the count.
- R4: A write to 0x12 stores only bit 3, the enable for this alarm. The register reads 0x00 after reset, and its other bits always read 0. While bit 3 is 0, a state change does not set the status bit.
- R5: A state change in either direction with the enable set makes bit 3 of 0x13 read 1. This takes effect from the second cycle after the final qualifying strobe.
- R6: A read of 0x13 returns the current value and then clears bit 3. If an enabled event lands in the same cycle as that read, the read returns the old value and the bit stays at 1.
- R7: `irq` is 1 exactly while status bit 3 and enable bit 3 are both 1.
- R8: A synchronous high `rst` clears the alarm state, both registers and `irq`.
- R9: Writes to 0x13 and 0x14 have no effect. A read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_vld | input | 1 | One-cycle strobe per received frame |
| frame_xa | input | 1 | First X bit of the frame |
| frame_xb | input | 1 | Second X bit of the frame |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a read of 0x13 clears it |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
The alarm filter is driven with four kinds of pattern:

- Runs of all-zero X pairs that are exactly long enough to declare the alarm.
- Runs that a single agreeing frame breaks, which separates a true consecutive count from a plain tally.
- Clearing runs made of mixed X pairs (1/0 and 0/1), which show that any non-zero pair counts toward a clear.
- A state change with the enable bit low, which separates a masked event from a missed one.

A clearing event is also timed to land in the same cycle as a status read. This shows that the read-clear gives way to a new event.

// File: rtl/fe_alarm_pkg.sv
package fe_alarm_pkg;

    localparam logic [7:0] ADDR_ENABLE = 8'h12;
    localparam logic [7:0] ADDR_STATUS = 8'h13;
    localparam logic [7:0] ADDR_STATE  = 8'h14;

    // Source bit layout shared by the enable and status registers.
    typedef struct packed {
        logic cp_err;
        logic los;
        logic ais;
        logic idle;
        logic ferf;
        logic aic;
        logic oof;
        logic p_err;
    } src_bits_t;

    typedef struct packed {
        logic xa;
        logic xb;
    } xpair_t;

    // True when the X pair argues for the alarm.
    function automatic logic xpair_alarm(input xpair_t p);
        return (p.xa == 1'b0) && (p.xb == 1'b0);
    endfunction

endpackage

// File: rtl/fe_persist.sv
module fe_persist
    import fe_alarm_pkg::*;
#(
    parameter int PERSIST = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   vld,
    input  xpair_t pair,
    output logic   state,
    output logic   evt
);
    localparam int CW = (PERSIST > 1) ? $clog2(PERSIST) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

    logic [CW-1:0] cnt_q;
    logic          against;

    assign against = (xpair_alarm(pair) != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= 1'b0;
            cnt_q <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (vld) begin
                if (!against) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    state <= ~state;
                    cnt_q <= '0;
                    evt   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R3: the run counter never passes its final value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R1, R2: state moves only on a frame strobe
    p_flip_on_frame_r1: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(state));

    // R2: every change of state is accompanied by an event
    p_flip_flags_evt_r2: assert property (@(posedge clk) disable iff (rst)
        (vld && against && cnt_q == LAST) |=> evt);

endmodule

// File: rtl/fe_regs.sv
module fe_regs
    import fe_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  logic       state,
    input  logic [7:0] addr,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       irq
);
    src_bits_t en_q;
    src_bits_t st_q;
    src_bits_t wd;
    logic      rd_stat;
    logic      set_ev;

    assign wd      = src_bits_t'(wdata);
    assign rd_stat = rd && (addr == ADDR_STATUS);
    assign set_ev  = evt && en_q.ferf;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (wr && addr == ADDR_ENABLE)
                en_q.ferf <= wd.ferf;
            if (set_ev)
                st_q.ferf <= 1'b1;
            else if (rd_stat)
                st_q.ferf <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_ENABLE: rdata = en_q;
            ADDR_STATUS: rdata = st_q;
            ADDR_STATE:  rdata = {7'b0, state};
            default:     rdata = 8'h00;
        endcase
    end

    assign irq = |(st_q & en_q);

    // R5: an enabled event always leaves the status bit set
    p_evt_sets_status_r5: assert property (@(posedge clk) disable iff (rst)
        (evt && en_q.ferf) |=> st_q.ferf);

    // R6: a read with no competing event clears the bit
    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !evt) |=> !st_q.ferf);

    // R4: with no enabled event the bit can not rise
    p_masked_no_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!st_q.ferf && !(evt && en_q.ferf)) |=> !st_q.ferf);

    // R4: tied-off source bits stay zero
    p_tied_bits_r4: assert property (@(posedge clk) disable iff (rst)
        ((en_q & 8'hF7) == 8'h00) && ((st_q & 8'hF7) == 8'h00));

endmodule

// File: rtl/fe_alarm_irq.sv
module fe_alarm_irq
    import fe_alarm_pkg::*;
#(
    parameter int PERSIST = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_vld,
    input  logic       frame_xa,
    input  logic       frame_xb,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    xpair_t pair;
    logic   alarm;
    logic   change;

    assign pair = '{xa: frame_xa, xb: frame_xb};

    fe_persist #(.PERSIST(PERSIST)) u_persist (
        .clk   (clk),
        .rst   (rst),
        .vld   (frame_vld),
        .pair  (pair),
        .state (alarm),
        .evt   (change)
    );

    fe_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .evt   (change),
        .state (alarm),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .rd    (bus_rd),
        .rdata (bus_rdata),
        .irq   (irq)
    );

    // R8: the interrupt is low in the cycle after reset
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: tb/tb_fe_alarm_irq.sv
module tb_fe_alarm_irq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_vld = 1'b0;
    logic       frame_xa = 1'b1;
    logic       frame_xb = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fe_alarm_irq #(.PERSIST(3)) dut (
        .clk(clk), .rst(rst),
        .frame_vld(frame_vld), .frame_xa(frame_xa), .frame_xb(frame_xb),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: compares every read cycle against the queued expectation.
    always @(negedge clk) begin
        if (bus_rd) begin
            if (sb.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL scoreboard: read with no expectation, got %02h", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (bus_rdata !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: addr %02h read %02h expected %02h",
                             it.req, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic frame(input logic a, input logic b);
        @(posedge clk); #1;
        frame_vld = 1'b1; frame_xa = a; frame_xb = b;
        @(posedge clk); #1;
        frame_vld = 1'b0; frame_xa = 1'b1; frame_xb = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
        @(posedge clk); #1;
        sb.push_back('{exp: e, req: req});
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string req);
        n_chk++;
        if (irq !== e) begin
            n_err++;
            $display("FAIL %s: irq %b expected %b", req, irq, e);
        end
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        chk_irq(1'b0, "R8");
        rd(8'h12, 8'h00, "R8");
        rd(8'h13, 8'h00, "R8");
        rd(8'h14, 8'h00, "R8");

        wr(8'h12, 8'hFF);
        rd(8'h12, 8'h08, "R4");

        frame(0, 0); frame(0, 0);
        rd(8'h14, 8'h00, "R1");
        frame(1, 1);
        frame(0, 0); frame(0, 0);
        rd(8'h14, 8'h00, "R3");
        frame(0, 0);
        tick(2);
        rd(8'h14, 8'h01, "R1");
        chk_irq(1'b1, "R7");
        rd(8'h13, 8'h08, "R5");
        rd(8'h13, 8'h00, "R6");
        tick(1);
        chk_irq(1'b0, "R7");

        frame(1, 0); frame(0, 1); frame(1, 1);
        tick(2);
        rd(8'h14, 8'h00, "R2");
        rd(8'h13, 8'h08, "R5");

        wr(8'h12, 8'h00);
        frame(0, 0); frame(0, 0); frame(0, 0);
        tick(2);
        rd(8'h14, 8'h01, "R4");
        rd(8'h13, 8'h00, "R4");
        chk_irq(1'b0, "R7");

        wr(8'h13, 8'hFF);
        wr(8'h14, 8'h00);
        rd(8'h13, 8'h00, "R9");
        rd(8'h14, 8'h01, "R9");
        rd(8'h55, 8'h00, "R9");

        // Event coincides with a status read (R6)
        wr(8'h12, 8'h08);
        frame(0, 1); frame(0, 1);
        @(posedge clk); #1;
        frame_vld = 1'b1; frame_xa = 1'b0; frame_xb = 1'b1;
        @(posedge clk); #1;
        frame_vld = 1'b0; frame_xb = 1'b1; frame_xa = 1'b1;
        sb.push_back('{exp: 8'h00, req: "R6"});
        bus_rd = 1'b1; bus_addr = 8'h13;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk_irq(1'b1, "R6");
        rd(8'h13, 8'h08, "R6");

        // Reset clears everything (R8)
        wr(8'h12, 8'h08);
        frame(0, 0); frame(0, 0); frame(0, 0);
        tick(2);
        chk_irq(1'b1, "R7");
        @(posedge clk); #1; rst = 1'b1;
        tick(1); rst = 1'b0;
        chk_irq(1'b0, "R8");
        rd(8'h14, 8'h00, "R8");
        rd(8'h12, 8'h00, "R8");

        tick(2);
        n_chk++;
        if (sb.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", sb.size());
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule